// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Controller

This block is the interrupt front end of a four-channel counter/timer peripheral that shares one interrupt line with other devices in a priority daisy chain. Each channel's terminal-count event, if that channel's interrupt is enabled, becomes a pending request. The block pulls the shared request line low while its chain input permits. When the processor acknowledges, it moves the winning channel to in-service and drives that channel's vector onto the data bus.

Priority passes down the chain through the chain output. That output is high only when the chain input is high and this device has nothing pending and nothing in service. The block watches instruction fetches for the two-byte return-from-interrupt opcode (0xED then 0x4D). When it sees that sequence, it retires the highest-priority in-service channel, which reopens the chain below.

All control strobes are active low and sampled on the rising clock edge. The open-drain request line is modelled as a pull-down enable.

Top module: `irq_chain_ctl`

## Requirements
- R1: While `rst_n` is low, and after it returns high, nothing is pending or in service: `int_oe` is 0, `vec_oe` is 0 and `ieo` follows `iei`.
- R2: A channel becomes pending on the clock edge at which its `zc_evt` bit and its `irq_en` bit are both 1. An event on a channel whose enable is 0 has no effect.
- R3: With the default `NEST_EN`=1, `int_oe` is 1 exactly when `iei` is 1 and some pending channel has no in-service channel of equal or lower index. When `iei` is 0, `int_oe` is 0.
- R4: An acknowledge cycle is `m1_n` and `iorq_n` both low. At its first clock edge, with `iei` high and a request present, the eligible pending channel of lowest index (channel 0 highest priority) becomes in-service and leaves pending.
- R5: From the clock after the grant until the acknowledge ends, `vec_oe` is 1 and `vec_out` is {VEC_UPPER, channel[1:0], 0}. With the default VEC_UPPER=20, channels 0 to 3 give 0xA0, 0xA2, 0xA4 and 0xA6.
- R6: `ieo` is 1 only when `iei` is 1, no channel is pending and no channel is in service.
- R7: A fetch cycle is `m1_n` and `rd_n` both low. The block latches the byte on `data_in` during the fetch and decodes it when the fetch ends. A fetch of 0xED followed by a fetch of 0x4D, with `iei` high at the end of the second fetch, clears the lowest-index in-service channel.
- R8: Any other byte between 0xED and 0x4D cancels the sequence, and a lone 0x4D does nothing. A repeated 0xED keeps the sequence armed. A 0x4D that ends while `iei` is low clears nothing.
- R9: An acknowledge that begins while `iei` is low grants nothing, and `vec_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| zc_evt | input | NUM_CH | Per-channel terminal-count event pulses |
| irq_en | input | NUM_CH | Per-channel interrupt enables |
| iei | input | 1 | Daisy-chain priority input, active high |
| m1_n | input | 1 | Opcode-fetch cycle strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| data_in | input | DATA_W | Data bus as seen by the block |
| int_oe | output | 1 | Pull-down enable for the shared request line |
| ieo | output | 1 | Daisy-chain priority output, active high |
| vec_oe | output | 1 | Vector drive enable for the data bus |
| vec_out | output | DATA_W | Interrupt vector |

## Verification
The bench builds the block with its defaults: four channels, an 8-bit bus, VEC_UPPER of 20 and nested priority enabled. Four channels make all four vector codes reachable. They also allow the case where an event on a higher-priority channel breaks into a lower one that is already in service, while a lower-priority request stays masked behind an in-service channel. The 8-bit bus lets the fetch stream carry the real opcode bytes. That covers the interrupted, repeated and lone-suffix return sequences, and a return seen while the chain input is low.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
   localparam logic [7:0] OPC_PREFIX = 8'hED;
   localparam logic [7:0] OPC_RETURN = 8'h4D;

   typedef struct packed {
      logic ack_now;
      logic ack_start;
      logic reti_hit;
   } cyc_evt_t;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0]         req,
   output logic [N-1:0]         sel,
   output logic [$clog2(N)-1:0] idx,
   output logic                 any
);
   localparam int IW = $clog2(N);

   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign sel[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/irq_cycle_decode.sv
module irq_cycle_decode
   import irq_chain_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m1_n,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              iei,
   input  logic [DATA_W-1:0] data_in,
   output cyc_evt_t          evt
);
   localparam logic [DATA_W-1:0] PFX = DATA_W'(OPC_PREFIX);
   localparam logic [DATA_W-1:0] RET = DATA_W'(OPC_RETURN);

   logic ack_now, ack_q, fetch_now, fetch_q, fetch_end, armed_q;
   logic [DATA_W-1:0] byte_q;

   assign ack_now   = ~m1_n & ~iorq_n;
   assign fetch_now = ~m1_n & ~rd_n;
   assign fetch_end = fetch_q & ~fetch_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         fetch_q <= 1'b0;
         armed_q <= 1'b0;
         byte_q  <= '0;
      end else begin
         ack_q   <= ack_now;
         fetch_q <= fetch_now;
         if (fetch_now) byte_q <= data_in;
         if (fetch_end) armed_q <= (byte_q == PFX);
      end
   end

   assign evt.ack_now   = ack_now;
   assign evt.ack_start = ack_now & ~ack_q;
   assign evt.reti_hit  = fetch_end & armed_q & (byte_q == RET) & iei;

   // R8
   arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(fetch_q));
endmodule

// File: rtl/irq_chan_state.sv
module irq_chan_state #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] zc_evt,
   input  logic [N-1:0] irq_en,
   input  logic         grant,
   input  logic [N-1:0] gsel,
   input  logic         reti_hit,
   output logic [N-1:0] pend,
   output logic [N-1:0] insvc
);
   logic [N:0]   rseen;
   logic [N-1:0] rsel, pend_nx, insvc_nx;

   assign rseen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_ret
      assign rsel[i]    = insvc[i] & ~rseen[i];
      assign rseen[i+1] = rseen[i] | insvc[i];
   end

   assign pend_nx  = (pend & ~(gsel & {N{grant}})) | (zc_evt & irq_en);
   assign insvc_nx = (insvc & ~(rsel & {N{reti_hit}})) | (gsel & {N{grant}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend  <= '0;
         insvc <= '0;
      end else begin
         pend  <= pend_nx;
         insvc <= insvc_nx;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_chk
      // R2
      pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend[i]) |-> $past(zc_evt[i] & irq_en[i]));
      // R4
      insvc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(insvc[i]) |-> $past(grant & gsel[i]));
      // R7
      insvc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(insvc[i]) |-> $past(reti_hit));
   end
endmodule

// File: rtl/irq_chain_ctl.sv
module irq_chain_ctl
   import irq_chain_pkg::*;
#(
   parameter int          NUM_CH    = 4,
   parameter int          DATA_W    = 8,
   parameter int unsigned VEC_UPPER = 20,
   parameter bit          NEST_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] zc_evt,
   input  logic [NUM_CH-1:0] irq_en,
   input  logic              iei,
   input  logic              m1_n,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic [DATA_W-1:0] data_in,
   output logic              int_oe,
   output logic              ieo,
   output logic              vec_oe,
   output logic [DATA_W-1:0] vec_out
);
   localparam int CH_W = $clog2(NUM_CH);
   localparam int VU_W = DATA_W - CH_W - 1;

   if (NUM_CH < 2) begin : g_bad_ch
      $error("NUM_CH must be at least 2");
   end
   if (VU_W < 1) begin : g_bad_w
      $error("DATA_W too narrow for channel field");
   end
   if (DATA_W < 8) begin : g_bad_op
      $error("DATA_W must hold an opcode byte");
   end

   cyc_evt_t          evt;
   logic [NUM_CH-1:0] pend, insvc, elig, gsel;
   logic [CH_W-1:0]   gidx, ch_q;
   logic              any_elig, grant, own_q;

   irq_cycle_decode #(.DATA_W(DATA_W)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .m1_n    (m1_n),
      .iorq_n  (iorq_n),
      .rd_n    (rd_n),
      .iei     (iei),
      .data_in (data_in),
      .evt     (evt)
   );

   if (NEST_EN) begin : g_nest
      logic [NUM_CH-1:0] blk;
      assign blk[0] = insvc[0];
      for (genvar i = 1; i < NUM_CH; i++) begin : g_blk
         assign blk[i] = blk[i-1] | insvc[i];
      end
      assign elig = pend & ~blk;
   end else begin : g_flat
      assign elig = (|insvc) ? '0 : pend;
   end

   irq_prio_pick #(.N(NUM_CH)) u_pick (
      .req (elig),
      .sel (gsel),
      .idx (gidx),
      .any (any_elig)
   );

   assign grant = evt.ack_start & iei & any_elig;

   irq_chan_state #(.N(NUM_CH)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .zc_evt   (zc_evt),
      .irq_en   (irq_en),
      .grant    (grant),
      .gsel     (gsel),
      .reti_hit (evt.reti_hit),
      .pend     (pend),
      .insvc    (insvc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= 1'b0;
         ch_q  <= '0;
      end else if (grant) begin
         own_q <= 1'b1;
         ch_q  <= gidx;
      end else if (!evt.ack_now) begin
         own_q <= 1'b0;
      end
   end

   assign int_oe  = iei & any_elig;
   assign ieo     = iei & ~(|pend) & ~(|insvc);
   assign vec_oe  = evt.ack_now & own_q;
   assign vec_out = {VU_W'(VEC_UPPER), ch_q, 1'b0};

   // R4
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> ($countones(gsel) == 1));
   // R5
   vec_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe |-> $past(evt.ack_now));
   // R9
   no_grant_low_iei_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.ack_start && !iei) |=> !vec_oe);
   // R6
   ieo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ieo |-> (insvc == '0));
endmodule

// File: tb/sim_irq_chain_ctl.sv
module sim_irq_chain_ctl;
   localparam int CLK_T = 10;
   localparam logic [1:0] OP_EVT = 2'd0, OP_ACK = 2'd1, OP_FET = 2'd2;
   localparam int NV = 25;
   // entry: {op, arg, exp_int, exp_ieo, exp_vec}; EVT arg = {irq_en, zc_evt}
   localparam logic [19:0] TBL [NV] = '{
      {OP_EVT, 8'hF4, 1'b1, 1'b0, 8'h00},
      {OP_EVT, 8'hF2, 1'b1, 1'b0, 8'h00},
      {OP_ACK, 8'h00, 1'b0, 1'b0, 8'hA2},
      {OP_EVT, 8'hE1, 1'b0, 1'b0, 8'h00},
      {OP_EVT, 8'hF1, 1'b1, 1'b0, 8'h00},
      {OP_ACK, 8'h00, 1'b0, 1'b0, 8'hA0},
      {OP_FET, 8'hED, 1'b0, 1'b0, 8'h00},
      {OP_FET, 8'h4D, 1'b0, 1'b0, 8'h00},
      {OP_FET, 8'h4D, 1'b0, 1'b0, 8'h00},
      {OP_FET, 8'hED, 1'b0, 1'b0, 8'h00},
      {OP_FET, 8'hED, 1'b0, 1'b0, 8'h00},
      {OP_FET, 8'h4D, 1'b1, 1'b0, 8'h00},
      {OP_ACK, 8'h00, 1'b0, 1'b0, 8'hA4},
      {OP_FET, 8'hED, 1'b0, 1'b0, 8'h00},
      {OP_FET, 8'h00, 1'b0, 1'b0, 8'h00},
      {OP_FET, 8'h4D, 1'b0, 1'b0, 8'h00},
      {OP_FET, 8'hED, 1'b0, 1'b0, 8'h00},
      {OP_FET, 8'h4D, 1'b0, 1'b1, 8'h00},
      {OP_EVT, 8'hFA, 1'b1, 1'b0, 8'h00},
      {OP_ACK, 8'h00, 1'b0, 1'b0, 8'hA2},
      {OP_FET, 8'hED, 1'b0, 1'b0, 8'h00},
      {OP_FET, 8'h4D, 1'b1, 1'b0, 8'h00},
      {OP_ACK, 8'h00, 1'b0, 1'b0, 8'hA6},
      {OP_FET, 8'hED, 1'b0, 1'b0, 8'h00},
      {OP_FET, 8'h4D, 1'b0, 1'b1, 8'h00}
   };

   logic       clk = 1'b0, rst_n = 1'b0, iei = 1'b1;
   logic       m1_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1;
   logic [3:0] zc_evt = '0, irq_en = '0;
   logic [7:0] data_in = '0, vec_out;
   logic       int_oe, ieo, vec_oe;
   int n_chk = 0, n_fail = 0;

   always #(CLK_T/2) clk = ~clk;

   irq_chain_ctl u0 (
      .clk(clk), .rst_n(rst_n), .zc_evt(zc_evt), .irq_en(irq_en), .iei(iei),
      .m1_n(m1_n), .iorq_n(iorq_n), .rd_n(rd_n), .data_in(data_in),
      .int_oe(int_oe), .ieo(ieo), .vec_oe(vec_oe), .vec_out(vec_out)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_evt(logic [3:0] en, logic [3:0] zc);
      irq_en = en; zc_evt = zc;
      tick();
      zc_evt = '0;
      tick();
   endtask

   task automatic do_fetch(logic [7:0] b);
      m1_n = 1'b0; rd_n = 1'b0; data_in = b;
      tick();
      m1_n = 1'b1; rd_n = 1'b1; data_in = '0;
      tick();
   endtask

   task automatic ack_begin();
      m1_n = 1'b0; iorq_n = 1'b0;
      tick();
   endtask

   task automatic ack_end();
      m1_n = 1'b1; iorq_n = 1'b1;
      tick();
   endtask

   initial begin
      #(CLK_T * 100000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [1:0] op;
      logic [7:0] arg, ev;
      logic       ei, eo;
      tick(); tick();
      // R1 while reset is held
      chk("R1 int_oe in reset", {7'd0, int_oe}, 8'd0);
      chk("R1 ieo in reset", {7'd0, ieo}, 8'd1);
      rst_n = 1'b1;
      tick();
      chk("R1 int_oe after reset", {7'd0, int_oe}, 8'd0);
      chk("R1 ieo after reset", {7'd0, ieo}, 8'd1);
      chk("R1 vec_oe after reset", {7'd0, vec_oe}, 8'd0);

      for (int k = 0; k < NV; k++) begin
         {op, arg, ei, eo, ev} = TBL[k];
         case (op)
            OP_EVT: begin
               do_evt(arg[7:4], arg[3:0]);
               chk("R2/R3 int_oe after event", {7'd0, int_oe}, {7'd0, ei});
               chk("R6 ieo after event", {7'd0, ieo}, {7'd0, eo});
            end
            OP_ACK: begin
               ack_begin();
               chk("R5 vec_oe during ack", {7'd0, vec_oe}, 8'd1);
               chk("R4/R5 vector during ack", vec_out, ev);
               chk("R4 int_oe after grant", {7'd0, int_oe}, {7'd0, ei});
               ack_end();
               chk("R5 vec_oe after ack", {7'd0, vec_oe}, 8'd0);
               chk("R6 ieo after ack", {7'd0, ieo}, {7'd0, eo});
            end
            default: begin
               do_fetch(arg);
               chk("R7/R8 int_oe after fetch", {7'd0, int_oe}, {7'd0, ei});
               chk("R7/R8 ieo after fetch", {7'd0, ieo}, {7'd0, eo});
            end
         endcase
      end

      // R3 / R9: chain input low blocks request and grant
      iei = 1'b0;
      do_evt(4'hF, 4'h1);
      chk("R3 int_oe with iei low", {7'd0, int_oe}, 8'd0);
      chk("R6 ieo with iei low", {7'd0, ieo}, 8'd0);
      ack_begin();
      chk("R9 vec_oe with iei low", {7'd0, vec_oe}, 8'd0);
      ack_end();
      iei = 1'b1;
      #1;
      chk("R3 int_oe after iei rises", {7'd0, int_oe}, 8'd1);
      ack_begin();
      chk("R5 vector ch0 after iei rises", vec_out, 8'hA0);
      ack_end();
      // R8: return sequence with iei low clears nothing
      iei = 1'b0;
      do_fetch(8'hED);
      do_fetch(8'h4D);
      iei = 1'b1;
      #1;
      chk("R8 ieo stays low after return with iei low", {7'd0, ieo}, 8'd0);
      do_fetch(8'hED);
      do_fetch(8'h4D);
      chk("R7 ieo after return with iei high", {7'd0, ieo}, 8'd1);

      // R1: reset clears a pending request
      do_evt(4'hF, 4'h4);
      chk("R2 int_oe before reset", {7'd0, int_oe}, 8'd1);
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      chk("R1 int_oe after mid-run reset", {7'd0, int_oe}, 8'd0);
      chk("R1 ieo after mid-run reset", {7'd0, ieo}, 8'd1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule